// File: doc/BRIEF.md
# Clock-sampled static byte memory with write-on-release and activity power state

This block models a 2048 x 8 static memory whose three active-low strobes (select, write, output enable) and its address and data pins are oversampled by a fast system clock. Every pin passes through one register stage. The block compares each sample with the one before it, and from those two samples it decides whether the data bus is driven, released (high impedance), or carrying a write. The shared three-state data bus is split into three signals: a data-in vector, a data-out vector, and a drive flag. When the drive flag is low, the data-out vector is held at zero.

A write is not committed while the strobes overlap. The byte is stored on the cycle the overlap of select-low and write-low ends, whichever strobe releases first, and the stored value is the address and data sampled last inside the overlap. The storage is split into 128 rows of 16 byte columns. The seven upper address bits pick the row and the four lower bits pick the column.

A separate tracker reports whether the block is active or in standby. It wakes on a fixed set of pin transitions and falls back to standby after a parameterised number of idle cycles.

Top module: `sramctl_top`

## Requirements
- R1: While reset is held and right after it is released, `bus_drive` is 0, `bus_out` is 0 and `pwr_active` is 0.
- R2: When `sel_n`=0, `oen_n`=0 and `wen_n`=1 are applied before clock edge N, `bus_drive` is 1 after edge N+1 and `bus_out` carries the byte stored at `addr`.
- R3: When any of `sel_n`=1, `oen_n`=1 or `wen_n`=0 is applied before edge N, then after edge N+1 `bus_drive` is 0 and `bus_out` is 0. This includes a write whose write strobe fell before or together with the select, and a write that was ended by the select.
- R4: A write whose overlap ends with `wen_n` rising while `sel_n` stays low stores the byte at its address.
- R5: A write whose overlap ends with `sel_n` rising, while `wen_n` is still low, stores the byte at its address.
- R6: When `din` changes during the overlap, the value stored is the last value sampled before the overlap ends.
- R7: Each of the 2048 addresses is a separate byte: row = `addr[10:4]`, column = `addr[3:0]`. Writes to the same row with different columns, or to the same column with different rows, do not disturb one another.
- R8: `wen_n`=0 while `sel_n`=1 stores nothing.
- R9: When a write ends by `wen_n` rising while `sel_n` and `oen_n` stay low, the first cycle the bus is driven already shows the new byte.
- R10: A falling `sel_n`, a falling `wen_n` while `sel_n`=0, an `addr` change while `sel_n`=0, or a `din` change while `sel_n`=0 and `wen_n`=0, applied before edge N, makes `pwr_active` 1 after edges N+1 through N+PD_CYCLES. It is 0 again after edge N+PD_CYCLES+1 if no further wake event occurs.
- R11: `addr`, `din` or `wen_n` changes while `sel_n`=1, and `din` changes while `wen_n`=1, do not leave standby.
- R12: A wake event while already active restarts the full PD_CYCLES interval from that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| wen_n | input | 1 | Active-low write strobe |
| oen_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address, row in upper bits |
| din | input | DATA_W | Write data from the shared bus |
| bus_out | output | DATA_W | Read data toward the shared bus, zero when released |
| bus_drive | output | 1 | High when the block drives the shared bus |
| pwr_active | output | 1 | High in the active power state, low in standby |

## Verification
Writes are ended in three ways: the write strobe released first, the select released first, and the write strobe released under a held read. Because each ending has its own expected stored byte and bus behaviour, a mistake in the end-of-overlap detection shows up as wrong data on a later read. Reads sweep addresses that share a row but differ in column, and addresses that share a column but differ in row, which separates the row/column split from the word decode. The power state is driven by each of the four wake transitions in isolation. Look-alike transitions are applied with the select high or the write strobe high, and a second event is applied mid-interval, so an over-eager wake condition, a wrong timeout length and a missing restart each change the observed active window.

// File: rtl/sramctl_pkg.sv
package sramctl_pkg;

    localparam int DEF_ADDR_W   = 11;
    localparam int DEF_DATA_W   = 8;
    localparam int DEF_ROW_W    = 7;
    localparam int DEF_PD_CYCLES = 8;

    // Sampled strobe levels, all active low
    typedef struct packed {
        logic sel_n;
        logic wen_n;
        logic oen_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, wen_n: 1'b1, oen_n: 1'b1};

    typedef enum logic [1:0] {
        BUS_RELEASE = 2'd0,
        BUS_READ    = 2'd1,
        BUS_WRITE   = 2'd2
    } bus_mode_e;

    function automatic bus_mode_e classify(input strobe_t s);
        if (s.sel_n)
            return BUS_RELEASE;
        else if (!s.wen_n)
            return BUS_WRITE;
        else if (!s.oen_n)
            return BUS_READ;
        else
            return BUS_RELEASE;
    endfunction

endpackage

// File: rtl/sramctl_sampler.sv
module sramctl_sampler
    import sramctl_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           pin_strobe,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [DATA_W-1:0] pin_din,
    output strobe_t           cur_strobe,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_din,
    output strobe_t           prv_strobe,
    output logic [ADDR_W-1:0] prv_addr,
    output logic [DATA_W-1:0] prv_din
);

    typedef struct packed {
        strobe_t           strobe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
    } sample_t;

    typedef struct packed {
        sample_t cur;
        sample_t prv;
    } smp_state_t;

    localparam sample_t SAMPLE_IDLE = '{strobe: STROBE_IDLE, addr: '0, din: '0};

    smp_state_t smp_d, smp_q;

    always_comb begin
        smp_d            = smp_q;
        smp_d.prv        = smp_q.cur;
        smp_d.cur.strobe = pin_strobe;
        smp_d.cur.addr   = pin_addr;
        smp_d.cur.din    = pin_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{cur: SAMPLE_IDLE, prv: SAMPLE_IDLE};
        end else begin
            smp_q <= smp_d;
        end
    end

    assign cur_strobe = smp_q.cur.strobe;
    assign cur_addr   = smp_q.cur.addr;
    assign cur_din    = smp_q.cur.din;
    assign prv_strobe = smp_q.prv.strobe;
    assign prv_addr   = smp_q.prv.addr;
    assign prv_din    = smp_q.prv.din;

endmodule

// File: rtl/sramctl_array.sv
module sramctl_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int COL_W = ADDR_W - ROW_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;

    logic [ROW_W-1:0] wr_row, rd_row;
    logic [COL_W-1:0] wr_col, rd_col;
    logic [DATA_W-1:0] col_rd [COLS];

    assign wr_row = wr_addr[ADDR_W-1:COL_W];
    assign wr_col = wr_addr[COL_W-1:0];
    assign rd_row = rd_addr[ADDR_W-1:COL_W];
    assign rd_col = rd_addr[COL_W-1:0];

    // One byte-wide bank per column; the row indexes inside the bank
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [DATA_W-1:0] bank [ROWS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_col == COL_W'(c))) begin
                bank[wr_row] <= wr_data;
            end
        end

        assign col_rd[c] = bank[rd_row];
    end

    assign rd_data = col_rd[rd_col];

endmodule

// File: rtl/sramctl_power.sv
module sramctl_power #(
    parameter int PD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    output logic active
);

    localparam int CNT_W = $clog2(PD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PD_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } pwr_state_t;

    pwr_state_t pwr_d, pwr_q;

    always_comb begin
        pwr_d = pwr_q;
        if (wake) begin
            pwr_d.remain = CNT_LOAD;
        end else if (pwr_q.remain != '0) begin
            pwr_d.remain = pwr_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= '{remain: '0};
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign active = (pwr_q.remain != '0);

endmodule

// File: rtl/sramctl_top.sv
module sramctl_top
    import sramctl_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int ROW_W     = DEF_ROW_W,
    parameter int PD_CYCLES = DEF_PD_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic              oen_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive,
    output logic              pwr_active
);

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } out_state_t;

    strobe_t           pin_strobe;
    strobe_t           cur_strobe, prv_strobe;
    logic [ADDR_W-1:0] cur_addr, prv_addr;
    logic [DATA_W-1:0] cur_din, prv_din;
    logic [DATA_W-1:0] arr_rd;

    bus_mode_e cur_mode, prv_mode;
    logic      commit;
    logic      forward;
    logic      wake;
    logic      ev_sel_fall, ev_wen_fall, ev_addr_move, ev_din_move;

    out_state_t out_d, out_q;

    assign pin_strobe = '{sel_n: sel_n, wen_n: wen_n, oen_n: oen_n};

    sramctl_sampler #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_strobe (pin_strobe),
        .pin_addr   (addr),
        .pin_din    (din),
        .cur_strobe (cur_strobe),
        .cur_addr   (cur_addr),
        .cur_din    (cur_din),
        .prv_strobe (prv_strobe),
        .prv_addr   (prv_addr),
        .prv_din    (prv_din)
    );

    assign cur_mode = classify(cur_strobe);
    assign prv_mode = classify(prv_strobe);

    // Store on the cycle the select/write overlap ends, whichever strobe let go
    assign commit  = (prv_mode == BUS_WRITE) && (cur_mode != BUS_WRITE);
    assign forward = commit && (prv_addr == cur_addr);

    sramctl_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ROW_W  (ROW_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (prv_addr),
        .wr_data (prv_din),
        .rd_addr (cur_addr),
        .rd_data (arr_rd)
    );

    always_comb begin
        out_d = out_q;
        if (cur_mode == BUS_READ) begin
            out_d.drive = 1'b1;
            out_d.data  = forward ? prv_din : arr_rd;
        end else begin
            out_d.drive = 1'b0;
            out_d.data  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{drive: 1'b0, data: '0};
        end else begin
            out_q <= out_d;
        end
    end

    // Wake events, judged on the current and previous samples
    assign ev_sel_fall  = prv_strobe.sel_n && !cur_strobe.sel_n;
    assign ev_wen_fall  = prv_strobe.wen_n && !cur_strobe.wen_n && !cur_strobe.sel_n;
    assign ev_addr_move = (cur_addr != prv_addr) && !cur_strobe.sel_n;
    assign ev_din_move  = (cur_din != prv_din) && !cur_strobe.sel_n && !cur_strobe.wen_n;
    assign wake = ev_sel_fall || ev_wen_fall || ev_addr_move || ev_din_move;

    sramctl_power #(
        .PD_CYCLES (PD_CYCLES)
    ) u_power (
        .clk    (clk),
        .rst_n  (rst_n),
        .wake   (wake),
        .active (pwr_active)
    );

    assign bus_out   = out_q.data;
    assign bus_drive = out_q.drive;

endmodule

// File: rtl/sramctl_checker.sv
module sramctl_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              wen_n,
    input logic              oen_n,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_drive,
    input logic              pwr_active
);

    // Cycles since reset release, saturating, so $past never reaches before it
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bus_drive && !pwr_active && bus_out == '0));

    p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(sel_n, 2) && !$past(oen_n, 2) && $past(wen_n, 2))
        |-> bus_drive);

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && ($past(sel_n, 2) || $past(oen_n, 2) || !$past(wen_n, 2)))
        |-> (!bus_drive && bus_out == '0));

    p_select_wakes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(sel_n, 3) && !$past(sel_n, 2)) |-> pwr_active);

    p_deselected_sleeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(sel_n, 2) && !$past(pwr_active)) |-> !pwr_active);

endmodule

bind sramctl_top sramctl_checker #(
    .DATA_W (DATA_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .wen_n      (wen_n),
    .oen_n      (oen_n),
    .bus_out    (bus_out),
    .bus_drive  (bus_drive),
    .pwr_active (pwr_active)
);

// File: tb/sramctl_top_test.sv
module sramctl_top_test;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int PD = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wen_n = 1'b1;
    logic          oen_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] bus_out;
    logic          bus_drive;
    logic          pwr_active;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [DW-1:0] ref_mem [1 << AW];

    typedef struct {
        int            due;
        logic          en;
        logic [DW-1:0] data;
        string         req;
    } item_t;

    item_t sbq[$];

    sramctl_top #(
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .ROW_W     (7),
        .PD_CYCLES (PD)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (sel_n),
        .wen_n      (wen_n),
        .oen_n      (oen_n),
        .addr       (addr),
        .din        (din),
        .bus_out    (bus_out),
        .bus_drive  (bus_drive),
        .pwr_active (pwr_active)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items on the cycle they fall due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            check(bus_drive === it.en, it.req, "bus_drive", 32'(bus_drive), 32'(it.en));
            check(bus_out === it.data, it.req, "bus_out", 32'(bus_out), 32'(it.data));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic s, input logic w, input logic o,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel_n = s;
        wen_n = w;
        oen_n = o;
        addr  = a;
        din   = d;
    endtask

    // Expect the bus two edges after the pins just driven
    task automatic expect_bus(input logic en, input logic [DW-1:0] d, input string req);
        item_t it;
        it.due  = cyc + 2;
        it.en   = en;
        it.data = d;
        it.req  = req;
        sbq.push_back(it);
    endtask

    task automatic write_wen_end(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(0, 1, 1, a, 0);  expect_bus(0, 0, "R3"); tick();
        drive(0, 0, 1, a, d);  expect_bus(0, 0, "R3"); tick();
        tick();
        drive(0, 1, 1, a, d);  expect_bus(0, 0, "R3"); tick();
        drive(1, 1, 1, a, d);  tick();
        ref_mem[a] = d;
    endtask

    // Write strobe low before select, select releases first
    task automatic write_sel_end(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(1, 1, 0, a, 0);  tick();
        drive(1, 0, 0, a, d);  expect_bus(0, 0, "R3"); tick();
        drive(0, 0, 0, a, d);  expect_bus(0, 0, "R3"); tick();
        drive(1, 0, 0, a, d);  expect_bus(0, 0, "R3"); tick();
        drive(1, 1, 0, a, d);  expect_bus(0, 0, "R3"); tick();
        ref_mem[a] = d;
    endtask

    task automatic read_at(input logic [AW-1:0] a, input string req);
        drive(0, 1, 0, a, 0);
        expect_bus(1, ref_mem[a], req);
        tick();
    endtask

    task automatic drain();
        drive(1, 1, 1, addr, din);
        repeat (4) tick();
    endtask

    task automatic settle_power(input string req);
        repeat (PD + 4) tick();
        check(pwr_active === 1'b0, req, "pwr_active before event", 32'(pwr_active), 0);
    endtask

    // Observe the active window after an event driven just before this call
    task automatic pulse_check(input logic prior, input string req);
        for (int k = 1; k <= PD + 3; k++) begin
            logic e;
            tick();
            e = (k == 1) ? prior : (k <= PD + 1);
            check(pwr_active === e, req, $sformatf("pwr_active at +%0d", k),
                  32'(pwr_active), 32'(e));
        end
    endtask

    task automatic hold_standby(input string req);
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(pwr_active === 1'b0, req, "pwr_active stays low", 32'(pwr_active), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bus_drive === 1'b0, "R1", "bus_drive in reset", 32'(bus_drive), 0);
        check(pwr_active === 1'b0, "R1", "pwr_active in reset", 32'(pwr_active), 0);
        rst_n = 1'b1;
        tick();
        check(bus_drive === 1'b0, "R1", "bus_drive after reset", 32'(bus_drive), 0);
        check(bus_out === '0, "R1", "bus_out after reset", 32'(bus_out), 0);
        check(pwr_active === 1'b0, "R1", "pwr_active after reset", 32'(pwr_active), 0);

        // R4 / R7: write-strobe-ended writes across rows and columns
        write_wen_end(11'h000, 8'hA5);
        write_wen_end(11'h7FF, 8'h3C);
        write_wen_end(11'h010, 8'h81);
        write_wen_end(11'h001, 8'h7E);
        write_wen_end(11'h011, 8'h42);
        // R5: select-ended write
        write_sel_end(11'h2A5, 8'hC3);

        read_at(11'h000, "R4");
        read_at(11'h7FF, "R4");
        read_at(11'h010, "R7");
        read_at(11'h001, "R7");
        read_at(11'h011, "R7");
        read_at(11'h2A5, "R5");
        drain();

        // R6: data moves inside the overlap, select ends it
        drive(0, 1, 1, 11'h155, 8'h00); tick();
        drive(0, 0, 1, 11'h155, 8'h11); tick();
        drive(0, 0, 1, 11'h155, 8'h22); tick();
        drive(1, 0, 1, 11'h155, 8'h22); tick();
        drive(1, 1, 1, 11'h155, 8'h22); tick();
        ref_mem[11'h155] = 8'h22;
        read_at(11'h155, "R6");
        drain();

        // R8: write strobe with select high stores nothing
        drive(1, 0, 0, 11'h000, 8'hFF); expect_bus(0, 0, "R3"); tick();
        tick();
        drive(1, 1, 1, 11'h000, 8'hFF); tick();
        read_at(11'h000, "R8");
        drain();

        // R3: write strobe with output enable low keeps the bus released
        drive(0, 1, 1, 11'h7FF, 8'h00); tick();
        drive(0, 0, 0, 11'h7FF, 8'h99); expect_bus(0, 0, "R3"); tick();
        drive(1, 0, 0, 11'h7FF, 8'h99); expect_bus(0, 0, "R3"); tick();
        drive(1, 1, 0, 11'h7FF, 8'h99); expect_bus(0, 0, "R3"); tick();
        drive(0, 1, 1, 11'h7FF, 8'h99); expect_bus(0, 0, "R3"); tick();
        ref_mem[11'h7FF] = 8'h99;
        read_at(11'h7FF, "R5");
        drain();

        // R9: write strobe released under a held read shows the new byte at once
        write_wen_end(11'h0F0, 8'h01);
        drive(0, 1, 0, 11'h0F0, 8'h00); tick();
        drive(0, 0, 0, 11'h0F0, 8'h5A); expect_bus(0, 0, "R3"); tick();
        drive(0, 1, 0, 11'h0F0, 8'h5A); expect_bus(1, 8'h5A, "R9"); tick();
        ref_mem[11'h0F0] = 8'h5A;
        read_at(11'h0F0, "R9");
        drain();

        // R10: select falling
        drive(1, 1, 1, 11'h123, 8'h00);
        settle_power("R10");
        drive(0, 1, 1, 11'h123, 8'h00);
        pulse_check(1'b0, "R10");
        // R10: write strobe falling with select low
        settle_power("R10");
        drive(0, 0, 1, 11'h123, 8'h00);
        pulse_check(1'b0, "R10");
        // R10: data change in the overlap
        settle_power("R10");
        drive(0, 0, 1, 11'h123, 8'h6D);
        pulse_check(1'b0, "R10");
        drive(0, 1, 1, 11'h123, 8'h6D); tick();
        ref_mem[11'h123] = 8'h6D;
        // R10: address change with select low
        settle_power("R10");
        drive(0, 1, 1, 11'h124, 8'h6D);
        pulse_check(1'b0, "R10");

        // R11: look-alike transitions that must not wake
        settle_power("R11");
        drive(0, 1, 1, 11'h124, 8'hE7);
        hold_standby("R11");
        drive(1, 1, 1, 11'h124, 8'hE7); tick();
        settle_power("R11");
        drive(1, 1, 1, 11'h3FF, 8'h18);
        hold_standby("R11");
        drive(1, 0, 1, 11'h3FF, 8'h18);
        hold_standby("R11");
        drive(1, 1, 1, 11'h3FF, 8'h18); tick();

        // R12: second event mid-interval restarts the window
        settle_power("R12");
        drive(0, 1, 1, 11'h3FF, 8'h18);
        repeat (3) tick();
        drive(0, 1, 1, 11'h200, 8'h18);
        pulse_check(1'b1, "R12");

        read_at(11'h123, "R6");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule